// File: doc/BRIEF.md
# Console Memory Map Address Decoder

This block sits between a CPU core and the memories and register files of a game console. On each access it takes a 24-bit bus address (an 8-bit bank and a 16-bit offset within the bank) and a read/write flag. Two static settings shape the decode: a cartridge layout selector and a fast-ROM enable. From these it decides whether the access lands in work RAM, on the peripheral register bus, in the CPU's own I/O registers, in cartridge ROM, or nowhere. It then gives a one-hot region select, the physical offset inside that region, and the speed class of the access.

A small timer holds the access open for the number of master clocks its speed class needs. It raises `ready` on the last of those clocks. Work RAM is 128 KiB. Its first 8 KiB is mirrored into the low offsets of the system banks. ROM can be laid out in 32 KiB chunks, in whole 64 KiB banks, or as an extended image split over two ROMs. The ROM offset is folded to the configured image size.

An access that decodes to nothing raises an open-bus flag, and the read data output keeps the last value read. Writes that decode to ROM are never enabled.

Top module: `memmap_decoder`

## Requirements
- R1: Banks 0x7E and 0x7F select work RAM (`region_sel` bit 0) for every offset, with physical offset {bank bit 0, 16-bit offset}, so 0x7F0000–0x7F1FFF is separate RAM at 0x10000–0x11FFF.
- R2: In system banks (0x00–0x3F, 0x80–0xBF), offsets 0x0000–0x1FFF select work RAM with physical offset equal to the 16-bit offset, the same bytes as 0x7E0000–0x7E1FFF.
- R3: In system banks, offsets 0x2100–0x21FF select the peripheral bus (`region_sel` bit 1, physical offset = offset − 0x2100), and 0x4000–0x43FF select CPU I/O registers (bit 2, physical offset = offset − 0x4000). Other offsets below 0x8000 decode to nothing (bit 4).
- R4: With `map_kind` = 0 (32 KiB chunks), offsets 0x8000–0xFFFF select ROM (bit 3) in every bank except 0x7E/0x7F, with raw offset (bank mod 0x80)·0x8000 + (offset − 0x8000).
- R5: With `map_kind` = 1 or 3 (64 KiB banks), banks 0x40–0x7D and 0xC0–0xFF are ROM for every offset, and system banks are ROM at 0x8000–0xFFFF, with raw offset (bank mod 0x40)·0x10000 + offset.
- R6: With `map_kind` = 2 (extended), ROM decodes as in R5, and banks below 0x80 add 0x400000 to the raw offset, so the upper halves of banks 0x00–0x3F come from the second ROM.
- R7: With `map_kind` = 0, offsets 0x0000–0x7FFF of banks 0x40–0x7D and 0xC0–0xFF decode to nothing.
- R8: `speed_fast` is 1 only for ROM in banks 0x80–0xFF while `fast_rom` is 1. `ready` is high for exactly one cycle: the 8th cycle after the start edge for slow accesses, the 6th for fast ones, counting the cycle after the start edge as the first.
- R9: `wr_enable` is 1 during a write to work RAM, the peripheral bus or CPU I/O, and 0 for a write that decodes to ROM or to nothing.
- R10: When an access decodes to nothing, `open_bus` is 1, and `cpu_rdata` keeps its previous value. A mapped read loads `bus_rdata` into `cpu_rdata` at the edge that ends the access, and writes leave it unchanged.
- R11: The ROM physical offset is the raw offset modulo 2^`rom_size_log2`. Values of 23 and above apply no folding.
- R12: After reset, `region_sel` is 0, `ready` and `open_bus` are 0, and `cpu_rdata` is 0. During an access exactly one `region_sel` bit is set, and it stays stable until `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_start | input | 1 | Begin an access; taken when idle or in the `ready` cycle |
| acc_addr | input | 24 | Bank (bits 23:16) and offset (15:0) |
| acc_write | input | 1 | 1 = write, 0 = read |
| map_kind | input | 2 | ROM layout: 0 chunked, 1/3 whole-bank, 2 extended |
| fast_rom | input | 1 | Enables the fast speed class for upper-bank ROM |
| rom_size_log2 | input | 5 | log2 of ROM image size in bytes |
| bus_rdata | input | 8 | Read data returned by the selected region |
| region_sel | output | 5 | One-hot: bit0 RAM, bit1 peripheral, bit2 CPU I/O, bit3 ROM, bit4 none |
| phys_off | output | 23 | Offset inside the selected region |
| speed_fast | output | 1 | 1 = fast class (6 clocks), 0 = slow (8 clocks) |
| wr_enable | output | 1 | Write is allowed to reach the region |
| ready | output | 1 | Last cycle of the access |
| open_bus | output | 1 | Access hits no region |
| cpu_rdata | output | 8 | Read data held for the CPU |

## Verification
The bench goes after range edges: 0x1FFF against 0x2000, 0x21FF against 0x2200, and 0x43FF against 0x4400. A decoder with an off-by-one compare would send these to the wrong region or leave a hole. It checks that bank 0x7F's low page lands above 0x10000, because a design that mirrors it would alias it onto the shared 8 KiB. In each layout it reads the upper halves of the system banks and the 0x40-and-up banks. A wrong bank fold or a missing second-ROM offset shows up as a wrong `phys_off`. It also checks ROM writes, fast-ROM timing per bank half, image-size folding, and that `cpu_rdata` survives open-bus reads. A design that got these wrong would enable a ROM write, count the wrong number of clocks, or hand stale or foreign data to the CPU.

// File: rtl/memmap_pkg.sv
// Shared types for the console memory map decoder.
// Assumes a 24-bit address split into an 8-bit bank and a 16-bit offset.
package memmap_pkg;

    // One-hot region codes; bit positions are visible on region_sel.
    typedef enum logic [4:0] {
        RG_WRAM   = 5'b00001,
        RG_PERIPH = 5'b00010,
        RG_CPUREG = 5'b00100,
        RG_ROM    = 5'b01000,
        RG_NONE   = 5'b10000
    } region_e;

    // Cartridge ROM layout selector.
    typedef enum logic [1:0] {
        MAP_CHUNK = 2'd0,
        MAP_WHOLE = 2'd1,
        MAP_EXT   = 2'd2,
        MAP_RSVD  = 2'd3
    } map_e;

    // Fixed boundaries of the system-bank low half.
    localparam logic [15:0] LOWRAM_LAST = 16'h1FFF;
    localparam logic [7:0]  PERIPH_PAGE = 8'h21;
    localparam logic [5:0]  CPUREG_BLK  = 6'b010000;
    localparam logic [6:0]  WRAM_BANKS  = 7'h3F;

endpackage

// File: rtl/mm_region_decode.sv
// Region decoder: classifies a bank/offset pair into one memory region.
// Assumes banks 0x7E/0x7F are RAM in every layout; system banks are
// those with bank bit 6 clear.
module mm_region_decode
    import memmap_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int OFF_W  = 16
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [OFF_W-1:0]  offset,
    input  map_e              layout,
    output region_e           region
);

    logic wram_bank;
    logic sys_bank;
    logic upper_half;

    // Bank class flags used by the region choice.
    always_comb begin
        wram_bank  = (bank[BANK_W-1:1] == WRAM_BANKS);
        sys_bank   = ~bank[BANK_W-2];
        upper_half = offset[OFF_W-1];
    end

    // Region choice in priority order: full RAM banks, system banks, ROM banks.
    always_comb begin
        region = RG_NONE;
        if (wram_bank) begin
            region = RG_WRAM;
        end else if (sys_bank) begin
            if (offset <= LOWRAM_LAST)
                region = RG_WRAM;
            else if (offset[OFF_W-1:8] == PERIPH_PAGE)
                region = RG_PERIPH;
            else if (offset[OFF_W-1:10] == CPUREG_BLK)
                region = RG_CPUREG;
            else if (upper_half)
                region = RG_ROM;
        end else begin
            if (layout != MAP_CHUNK || upper_half)
                region = RG_ROM;
        end
    end

endmodule

// File: rtl/mm_rom_map.sv
// ROM offset mapper: folds bank and offset into a ROM image offset for
// the selected layout, then wraps it to the configured image size.
// Assumes only ROM-decoded addresses use the result.
module mm_rom_map
    import memmap_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int OFF_W  = 16,
    parameter int ROM_AW = 23
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [OFF_W-1:0]  offset,
    input  map_e              layout,
    input  logic [4:0]        size_log2,
    output logic [ROM_AW-1:0] rom_off
);

    logic [ROM_AW-1:0] raw_off;
    logic [ROM_AW-1:0] size_mask;

    // Layout-specific bank folding.
    always_comb begin
        case (layout)
            MAP_CHUNK: raw_off = ROM_AW'({bank[6:0], offset[OFF_W-2:0]});
            MAP_EXT:   raw_off = ROM_AW'({~bank[BANK_W-1], bank[5:0], offset});
            default:   raw_off = ROM_AW'({bank[5:0], offset});
        endcase
    end

    // Image-size wrap; large sizes shift the one out and leave all ones.
    always_comb begin
        size_mask = (ROM_AW'(1) << size_log2) - ROM_AW'(1);
        rom_off   = raw_off & size_mask;
    end

endmodule

// File: rtl/mm_access_timer.sv
// Access timer: counts master clocks for one access and flags its last
// cycle. Assumes the speed class stays constant while an access is open.
module mm_access_timer #(
    parameter int SLOW_CLKS = 8,
    parameter int FAST_CLKS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic fast,
    output logic busy,
    output logic done
);

    localparam int MAX_CLKS = (SLOW_CLKS > FAST_CLKS) ? SLOW_CLKS : FAST_CLKS;
    localparam int CNT_W    = $clog2(MAX_CLKS);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Last count value for the current speed class.
    always_comb begin
        last = fast ? CNT_W'(FAST_CLKS - 1) : CNT_W'(SLOW_CLKS - 1);
        done = busy && (cnt == last);
    end

    // Busy flag and clock counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt  <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/memmap_decoder.sv
// Memory map decoder top: latches an access, decodes its region and
// physical offset, times it by speed class, and holds read data for the
// CPU. Assumes map_kind, fast_rom and rom_size_log2 are static.
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 8,
    parameter int ROM_AW    = 23,
    parameter int SLOW_CLKS = 8,
    parameter int FAST_CLKS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_start,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic [1:0]        map_kind,
    input  logic              fast_rom,
    input  logic [4:0]        rom_size_log2,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [4:0]        region_sel,
    output logic [ROM_AW-1:0] phys_off,
    output logic              speed_fast,
    output logic              wr_enable,
    output logic              ready,
    output logic              open_bus,
    output logic [DATA_W-1:0] cpu_rdata
);

    localparam int OFF_W  = 16;
    localparam int BANK_W = ADDR_W - OFF_W;
    localparam int WRAM_W = OFF_W + 1;

    logic [ADDR_W-1:0] lat_addr;
    logic              lat_write;
    logic              busy;
    logic              accept;
    logic [BANK_W-1:0] bank;
    logic [OFF_W-1:0]  offset;
    map_e              layout;
    region_e           region;
    logic [ROM_AW-1:0] rom_off;
    logic [WRAM_W-1:0] wram_off;
    logic              fast_acc;

    // Split the latched address and type the layout selector.
    always_comb begin
        bank   = lat_addr[ADDR_W-1:OFF_W];
        offset = lat_addr[OFF_W-1:0];
        layout = map_e'(map_kind);
        accept = acc_start && (!busy || ready);
    end

    // Capture address and direction when an access is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_write <= 1'b0;
        end else if (accept) begin
            lat_addr  <= acc_addr;
            lat_write <= acc_write;
        end
    end

    mm_region_decode #(
        .BANK_W (BANK_W),
        .OFF_W  (OFF_W)
    ) i_region (
        .bank   (bank),
        .offset (offset),
        .layout (layout),
        .region (region)
    );

    mm_rom_map #(
        .BANK_W (BANK_W),
        .OFF_W  (OFF_W),
        .ROM_AW (ROM_AW)
    ) i_rom (
        .bank      (bank),
        .offset    (offset),
        .layout    (layout),
        .size_log2 (rom_size_log2),
        .rom_off   (rom_off)
    );

    // Speed class: fast only for upper-bank ROM with fast ROM enabled.
    always_comb begin
        fast_acc = (region == RG_ROM) && bank[BANK_W-1] && fast_rom;
    end

    mm_access_timer #(
        .SLOW_CLKS (SLOW_CLKS),
        .FAST_CLKS (FAST_CLKS)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .fast  (fast_acc),
        .busy  (busy),
        .done  (ready)
    );

    // Work RAM offset: full banks keep bank bit 0, mirrors use the low 8 KiB.
    always_comb begin
        if (bank[BANK_W-1:1] == WRAM_BANKS)
            wram_off = {bank[0], offset};
        else
            wram_off = WRAM_W'(offset[12:0]);
    end

    // Output select, gated by an open access.
    always_comb begin
        region_sel = busy ? region : 5'b0;
        speed_fast = busy && fast_acc;
        open_bus   = busy && (region == RG_NONE);
        wr_enable  = busy && lat_write &&
                     (region == RG_WRAM || region == RG_PERIPH || region == RG_CPUREG);
        case (region)
            RG_WRAM:   phys_off = ROM_AW'(wram_off);
            RG_PERIPH: phys_off = ROM_AW'(offset[7:0]);
            RG_CPUREG: phys_off = ROM_AW'(offset[9:0]);
            RG_ROM:    phys_off = rom_off;
            default:   phys_off = '0;
        endcase
        if (!busy)
            phys_off = '0;
    end

    // Read data hold: load on a mapped read's last cycle, else keep.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cpu_rdata <= '0;
        else if (ready && !lat_write && region != RG_NONE)
            cpu_rdata <= bus_rdata;
    end

endmodule

// File: rtl/memmap_checker.sv
// Property checker for the memory map decoder, bound to every instance.
// Assumes it only observes the top-level ports.
module memmap_checker #(
    parameter int DATA_W = 8,
    parameter int ROM_AW = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        region_sel,
    input logic [ROM_AW-1:0] phys_off,
    input logic              speed_fast,
    input logic              wr_enable,
    input logic              ready,
    input logic              open_bus,
    input logic [DATA_W-1:0] cpu_rdata
);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(region_sel)); // R12

    AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (region_sel != 5'b0 && !ready) |=> ($stable(region_sel) && $stable(phys_off))); // R12

    AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        region_sel[3] |-> !wr_enable); // R9

    AST_RAM_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (region_sel[0] || region_sel[1] || region_sel[2]) |-> !speed_fast); // R8

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready); // R8

    AST_OPEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && open_bus) |=> $stable(cpu_rdata)); // R10

    AST_PERIPH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        region_sel[1] |-> (phys_off[ROM_AW-1:8] == '0)); // R3

    AST_OPEN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        open_bus |-> !wr_enable); // R9

endmodule

bind memmap_decoder memmap_checker #(
    .DATA_W (DATA_W),
    .ROM_AW (ROM_AW)
) i_memmap_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .region_sel (region_sel),
    .phys_off   (phys_off),
    .speed_fast (speed_fast),
    .wr_enable  (wr_enable),
    .ready      (ready),
    .open_bus   (open_bus),
    .cpu_rdata  (cpu_rdata)
);

// File: tb/test_memmap_decoder.sv
// Scoreboard bench: the driver computes expected decodes from the
// requirements and queues them; the monitor compares at each ready.
module test_memmap_decoder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_start = 1'b0;
    logic [23:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic [1:0]  map_kind = 2'd0;
    logic        fast_rom = 1'b0;
    logic [4:0]  rom_size_log2 = 5'd22;
    logic [7:0]  bus_rdata = '0;
    logic [4:0]  region_sel;
    logic [22:0] phys_off;
    logic        speed_fast;
    logic        wr_enable;
    logic        ready;
    logic        open_bus;
    logic [7:0]  cpu_rdata;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    logic [7:0] last_rd = 8'h00;
    bit finished = 0;

    typedef struct {
        string       tag;
        logic [23:0] addr;
        logic [4:0]  region;
        logic [22:0] phys;
        logic        fast;
        logic        wen;
        logic [7:0]  rdata;
        int          start_cyc;
    } exp_t;

    exp_t sb[$];

    memmap_decoder i_memmap_decoder (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_start     (acc_start),
        .acc_addr      (acc_addr),
        .acc_write     (acc_write),
        .map_kind      (map_kind),
        .fast_rom      (fast_rom),
        .rom_size_log2 (rom_size_log2),
        .bus_rdata     (bus_rdata),
        .region_sel    (region_sel),
        .phys_off      (phys_off),
        .speed_fast    (speed_fast),
        .wr_enable     (wr_enable),
        .ready         (ready),
        .open_bus      (open_bus),
        .cpu_rdata     (cpu_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Reference decode written from the requirement text.
    task automatic ref_decode(input logic [23:0] a, output logic [4:0] rg, output logic [22:0] ph, output logic fa);
        int b, o, raw;
        b = int'(a[23:16]);
        o = int'(a[15:0]);
        rg = 5'b10000;
        ph = '0;
        raw = 0;
        if (b == 'h7E || b == 'h7F) begin
            rg = 5'b00001; ph = 23'((b - 'h7E) * 65536 + o);
        end else if (b < 'h40 || (b >= 'h80 && b < 'hC0)) begin
            if (o < 'h2000) begin rg = 5'b00001; ph = 23'(o); end
            else if (o >= 'h2100 && o <= 'h21FF) begin rg = 5'b00010; ph = 23'(o - 'h2100); end
            else if (o >= 'h4000 && o < 'h4400) begin rg = 5'b00100; ph = 23'(o - 'h4000); end
            else if (o >= 'h8000) rg = 5'b01000;
        end else begin
            if (map_kind != 2'd0 || o >= 'h8000) rg = 5'b01000;
        end
        if (rg == 5'b01000) begin
            if (map_kind == 2'd0) raw = (b % 128) * 32768 + (o - 32768);
            else raw = (b % 64) * 65536 + o;
            if (map_kind == 2'd2 && b < 128) raw = raw + 'h400000;
            if (rom_size_log2 < 23) raw = raw % (1 << rom_size_log2);
            ph = 23'(raw);
        end
        fa = (rg == 5'b01000) && (b >= 128) && fast_rom;
    endtask

    // Driver: queue the expected item, run one access, wait for the monitor.
    task automatic issue(input string tag, input logic [23:0] a, input logic wr, input logic [7:0] data);
        exp_t e;
        @(negedge clk);
        acc_addr  = a;
        acc_write = wr;
        bus_rdata = data;
        acc_start = 1'b1;
        e.tag = tag;
        e.addr = a;
        ref_decode(a, e.region, e.phys, e.fast);
        e.wen = wr && (e.region[0] || e.region[1] || e.region[2]);
        if (!wr && !e.region[4]) last_rd = data;
        e.rdata = last_rd;
        @(negedge clk);
        acc_start = 1'b0;
        e.start_cyc = cyc;
        sb.push_back(e);
        do @(negedge clk); while (sb.size() != 0);
        @(negedge clk);
    endtask

    // Monitor: compare every completed access with the queue head.
    initial begin
        forever begin
            @(negedge clk);
            if (ready && sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "region_sel", 32'(region_sel), 32'(e.region));
                check(e.tag, "phys_off", 32'(phys_off), 32'(e.phys));
                check("R8", "speed_fast", 32'(speed_fast), 32'(e.fast));
                check("R8", "latency", 32'(cyc - e.start_cyc), e.fast ? 32'd5 : 32'd7);
                check("R9", "wr_enable", 32'(wr_enable), 32'(e.wen));
                check("R10", "open_bus", 32'(open_bus), 32'(e.region[4]));
                @(negedge clk);
                check("R8", "ready single", 32'(ready), 32'd0);
                check("R10", "cpu_rdata", 32'(cpu_rdata), 32'(e.rdata));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", "reset region_sel", 32'(region_sel), 32'd0);
        check("R12", "reset ready", 32'(ready), 32'd0);
        check("R12", "reset open_bus", 32'(open_bus), 32'd0);
        check("R12", "reset cpu_rdata", 32'(cpu_rdata), 32'd0);

        // Chunked layout, slow ROM, 4 MiB.
        map_kind = 2'd0; fast_rom = 1'b0; rom_size_log2 = 5'd22;
        issue("R1", 24'h7E1234, 1'b0, 8'h11);
        issue("R1", 24'h7F0010, 1'b0, 8'h22);
        issue("R2", 24'h001234, 1'b1, 8'h33);
        issue("R2", 24'hBF1FFF, 1'b0, 8'h44);
        issue("R3", 24'h002000, 1'b0, 8'h55);
        issue("R3", 24'h002100, 1'b0, 8'h66);
        issue("R3", 24'h0021FF, 1'b1, 8'h77);
        issue("R3", 24'h002200, 1'b0, 8'h88);
        issue("R3", 24'h804000, 1'b0, 8'h99);
        issue("R3", 24'h0043FF, 1'b0, 8'hAA);
        issue("R3", 24'h004400, 1'b0, 8'hBB);
        issue("R4", 24'h008000, 1'b0, 8'hCC);
        issue("R4", 24'h818000, 1'b0, 8'hDD);
        issue("R4", 24'h7D8000, 1'b0, 8'hEE);
        issue("R4", 24'hFFFFFF, 1'b0, 8'h01);
        issue("R7", 24'h401234, 1'b0, 8'h02);
        issue("R7", 24'hC07FFF, 1'b1, 8'h03);
        issue("R9", 24'h008000, 1'b1, 8'h04);
        fast_rom = 1'b1;
        issue("R8", 24'h808000, 1'b0, 8'h05);
        issue("R8", 24'h008000, 1'b0, 8'h06);
        issue("R8", 24'h7E0000, 1'b0, 8'h07);
        issue("R8", 24'h802100, 1'b0, 8'h08);

        // Whole-bank layout.
        map_kind = 2'd1;
        issue("R5", 24'hC01234, 1'b0, 8'h09);
        issue("R5", 24'h401234, 1'b0, 8'h0A);
        issue("R5", 24'h00FFFF, 1'b0, 8'h0B);
        issue("R5", 24'h3F8000, 1'b0, 8'h0C);
        issue("R5", 24'h004000, 1'b1, 8'h0D);
        issue("R9", 24'hC05555, 1'b1, 8'h0E);
        map_kind = 2'd3;
        issue("R5", 24'hFF0000, 1'b0, 8'h0F);

        // Extended layout, 8 MiB.
        map_kind = 2'd2; rom_size_log2 = 5'd23; fast_rom = 1'b0;
        issue("R6", 24'hC00000, 1'b0, 8'h10);
        issue("R6", 24'h400000, 1'b0, 8'h12);
        issue("R6", 24'h00FFC0, 1'b0, 8'h13);
        issue("R6", 24'h80FFC0, 1'b0, 8'h14);
        issue("R6", 24'h7D0000, 1'b0, 8'h15);

        // Image-size folding.
        map_kind = 2'd0; rom_size_log2 = 5'd20;
        issue("R11", 24'h208000, 1'b0, 8'h16);
        issue("R11", 24'h1FFFFF, 1'b0, 8'h17);
        map_kind = 2'd1; rom_size_log2 = 5'd19;
        issue("R11", 24'hC81234, 1'b0, 8'h18);

        // Open bus keeps the previous read value.
        map_kind = 2'd0;
        issue("R10", 24'h006000, 1'b0, 8'h5A);

        repeat (3) @(negedge clk);
        check("R12", "idle region_sel", 32'(region_sel), 32'd0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule